// File: doc/BRIEF.md
# SPI Flash Erase Command Front End

This block is the slave-side front end of a serial flash that handles erase commands. It oversamples the chip-select, serial clock and serial data lines with the core clock and shifts in a 32-bit command: an 8-bit opcode followed by a 24-bit address, most significant bit first. Three opcodes are recognised, each choosing an erase granule: a 4 KB sector, a 32 KB block or a 64 KB block. The address is cut down to the start of its granule.

When chip-select returns high after exactly 32 bits, the block runs three checks. The write-enable latch must be set, the target 64 KB region must not be protected, and no erase may be in progress. If all three pass, it sends one erase request to the array back end, with the granule base address and a size code. It then holds a busy status bit for a parameterised number of clock cycles. The busy time for sector erases and for block erases comes from two separate parameters.

The write-enable latch is set by a core-side pulse. It is cleared by any complete erase command that is examined, whether that command is accepted or refused. The block never drives the serial data output, so that line stays high-impedance for the whole erase command. The latch and the busy bit are both visible as status outputs.

Top module: `spi_erase_front`

## Requirements
- R1: After reset, `busy`, `wel` and `erase_req` are all 0.
- R2: Opcode 20h requests a 4 KB sector erase. `erase_size` is 2'b00 and `erase_base` equals the address with bits 11:0 cleared.
- R3: Opcode 52h requests a 32 KB block erase. `erase_size` is 2'b01 and `erase_base` equals the address with bits 14:0 cleared.
- R4: Opcode D8h requests a 64 KB block erase. `erase_size` is 2'b10 and `erase_base` equals the address with bits 15:0 cleared.
- R5: The bits are sampled on rising `spi_sck` edges while `spi_csn` is low: 8 opcode bits, then 24 address bits, MSB first. Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) work. Address bits at and above `MEM_AW` are ignored.
- R6: A command whose chip-select rises after any bit count other than exactly 32 is aborted. No request is made and `wel` is unchanged.
- R7: A `wren_set` pulse sets `wel`. An erase command that arrives while `wel` is 0 makes no request.
- R8: Bit i of `prot_map` protects the 64 KB region i (address bits 17:16 for the default size). An erase whose base lies in a protected region makes no request, but it still clears `wel`.
- R9: An accepted erase gives a one-cycle `erase_req` pulse on the third rising `clk` edge after `spi_csn` goes high. `wel` reads 0 from that same cycle.
- R10: `busy` rises together with `erase_req` and stays high for exactly `SECTOR_CYC` cycles after a sector erase, or exactly `BLOCK_CYC` cycles after either block erase.
- R11: An erase command whose completion is decided while `busy` is high makes no request and leaves `wel` unchanged. A command decided in the first cycle after `busy` falls is accepted.
- R12: A command with any other opcode makes no request and leaves `wel` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, used to oversample the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Serial chip-select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the device |
| wren_set | input | 1 | One-cycle pulse that sets the write-enable latch |
| prot_map | input | 2**(MEM_AW-16) | One protection bit per 64 KB region |
| erase_req | output | 1 | One-cycle erase request to the back end |
| erase_base | output | MEM_AW | Granule-aligned base address of the erase |
| erase_size | output | 2 | Granule code: 00 = 4 KB, 01 = 32 KB, 10 = 64 KB |
| busy | output | 1 | Status: an erase is in progress |
| wel | output | 1 | Status: write-enable latch |

## Verification
Two events can fall in the same cycle: the busy timer running out, and the end of a new erase command being decided. The bench provokes this by sending a second erase during a sector erase, timing the rise of chip-select against the cycle in which the first request was seen. It first places the decision in the last busy cycle and expects no request with the write-enable latch still set. It then places the decision one cycle later and expects a request on exactly the third edge after chip-select rises. A further erase with no new write-enable pulse confirms that the refused command left the latch untouched.

// File: rtl/spi_erase_pkg.sv
// Package: shared types and constants for the SPI erase front end.
// Assumes the command is always one opcode byte followed by 24 address bits.
package spi_erase_pkg;

    // Granule code sent to the back end with each erase request.
    typedef enum logic [1:0] {
        GRAN_4K  = 2'b00,
        GRAN_32K = 2'b01,
        GRAN_64K = 2'b10
    } gran_e;

    localparam logic [7:0] OPC_SECTOR = 8'h20;
    localparam logic [7:0] OPC_BLK32  = 8'h52;
    localparam logic [7:0] OPC_BLK64  = 8'hD8;

    localparam int OPC_BITS  = 8;
    localparam int ADDR_BITS = 24;
    localparam int CMD_BITS  = OPC_BITS + ADDR_BITS;

    // Number of low address bits that one granule spans.
    function automatic int unsigned gran_shift(input gran_e g);
        case (g)
            GRAN_4K:  return 12;
            GRAN_32K: return 15;
            default:  return 16;
        endcase
    endfunction

endpackage

// File: rtl/spi_erase_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes the inputs are slow compared with clk, so each bit is sampled on its own.
module spi_erase_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Later stages: let any metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/spi_erase_shifter.sv
// Module: command shifter and bit counter.
// Shifts in one bit per rising serial-clock edge while select is active.
// The counter saturates one past the command length, so any longer
// transfer is still seen as the wrong length. Assumes the edge strobe
// comes from synchronised signals.
module spi_erase_shifter #(
    parameter int CMD_BITS = 32,
    localparam int CNT_W   = $clog2(CMD_BITS + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_active,
    input  logic                bit_strobe,
    input  logic                bit_in,
    output logic [CNT_W-1:0]    bit_cnt,
    output logic [CMD_BITS-1:0] cmd_word
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CMD_BITS + 1);

    // Bit counter: cleared while deselected, saturating while selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                           bit_cnt <= '0;
        else if (!sel_active)                 bit_cnt <= '0;
        else if (bit_strobe && bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end

    // Shift register: MSB-first, newest bit enters at position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cmd_word <= '0;
        else if (sel_active && bit_strobe) cmd_word <= {cmd_word[CMD_BITS-2:0], bit_in};
    end

endmodule

// File: rtl/spi_erase_ctrl.sv
// Module: erase decision, write-enable latch and request register.
// At the end of a command it checks the length, the opcode, the busy
// state, the latch and region protection, then issues a request.
// Assumes MEM_AW >= 17 so that at least two 64 KB regions exist.
module spi_erase_ctrl
    import spi_erase_pkg::*;
#(
    parameter int MEM_AW = 18,
    localparam int NUM_RGN = 1 << (MEM_AW - 16),
    localparam int RGN_W   = MEM_AW - 16,
    localparam int CNT_W   = $clog2(CMD_BITS + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_end,
    input  logic [CNT_W-1:0]    bit_cnt,
    input  logic [CMD_BITS-1:0] cmd_word,
    input  logic                busy,
    input  logic                wren_set,
    input  logic [NUM_RGN-1:0]  prot_map,
    output logic                start,
    output gran_e               start_gran,
    output logic                erase_req,
    output logic [MEM_AW-1:0]   erase_base,
    output logic [1:0]          erase_size,
    output logic                wel
);

    logic [7:0]          opcode;
    logic [MEM_AW-1:0]   addr_lo;
    logic                opc_valid;
    gran_e               gran_c;
    logic [MEM_AW-1:0]   low_mask;
    logic [MEM_AW-1:0]   base_c;
    logic [RGN_W-1:0]    rgn_idx;
    logic                len_ok;
    logic                examined;
    logic                prot_hit;

    assign opcode  = cmd_word[CMD_BITS-1 -: OPC_BITS];
    assign addr_lo = cmd_word[MEM_AW-1:0];

    // Opcode decode: valid flag and granule selection.
    always_comb begin
        opc_valid = 1'b1;
        gran_c    = GRAN_4K;
        case (opcode)
            OPC_SECTOR: gran_c = GRAN_4K;
            OPC_BLK32:  gran_c = GRAN_32K;
            OPC_BLK64:  gran_c = GRAN_64K;
            default:    opc_valid = 1'b0;
        endcase
    end

    // Granule alignment: clear the address bits inside the granule.
    always_comb begin
        low_mask = (MEM_AW'(1) << gran_shift(gran_c)) - MEM_AW'(1);
        base_c   = addr_lo & ~low_mask;
        rgn_idx  = base_c[MEM_AW-1:16];
        prot_hit = prot_map[rgn_idx];
    end

    assign len_ok     = (bit_cnt == CNT_W'(CMD_BITS));
    assign examined   = sel_end && len_ok && opc_valid && !busy;
    assign start      = examined && wel && !prot_hit;
    assign start_gran = gran_c;

    // Write-enable latch: cleared by an examined erase, set by the core.
    always_ff @(posedge clk) begin
        if (!rst_n)        wel <= 1'b0;
        else if (examined) wel <= 1'b0;
        else if (wren_set) wel <= 1'b1;
    end

    // Request register: one-cycle pulse with the address and size held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_req  <= 1'b0;
            erase_base <= '0;
            erase_size <= GRAN_4K;
        end else begin
            erase_req <= start;
            if (start) begin
                erase_base <= base_c;
                erase_size <= gran_c;
            end
        end
    end

endmodule

// File: rtl/spi_erase_timer.sv
// Module: self-timed busy counter.
// Loads a sector or block duration on start and counts down to zero.
// Assumes start never comes while busy; the controller blocks that case.
module spi_erase_timer
    import spi_erase_pkg::*;
#(
    parameter int SECTOR_CYC = 1000,
    parameter int BLOCK_CYC  = 4000,
    localparam int MAX_CYC   = (SECTOR_CYC > BLOCK_CYC) ? SECTOR_CYC : BLOCK_CYC,
    localparam int TW        = $clog2(MAX_CYC + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  gran_e gran,
    output logic  busy
);

    logic [TW-1:0] remain;

    // Down-counter: busy lasts exactly the loaded number of cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= (gran == GRAN_4K) ? TW'(SECTOR_CYC) : TW'(BLOCK_CYC);
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/spi_erase_front.sv
// Module: top of the SPI flash erase front end.
// Synchronises the serial lines into clk, finds the clock and select
// edges, and ties together the shifter, the decision logic and the
// busy timer. Assumes clk runs well above twice the serial clock rate.
// The serial data output is never driven.
module spi_erase_front
    import spi_erase_pkg::*;
#(
    parameter int MEM_AW      = 18,
    parameter int SECTOR_CYC  = 1000,
    parameter int BLOCK_CYC   = 4000,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_RGN    = 1 << (MEM_AW - 16),
    localparam int CNT_W      = $clog2(CMD_BITS + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_csn,
    input  logic               spi_sck,
    input  logic               spi_mosi,
    input  logic               wren_set,
    input  logic [NUM_RGN-1:0] prot_map,
    output logic               erase_req,
    output logic [MEM_AW-1:0]  erase_base,
    output logic [1:0]         erase_size,
    output logic               busy,
    output logic               wel
);

    logic [2:0]          raw_in;
    logic [2:0]          syn_in;
    logic                csn_s, sck_s, mosi_s;
    logic                csn_d, sck_d;
    logic                sck_rise, sel_end;
    logic [CNT_W-1:0]    bit_cnt;
    logic [CMD_BITS-1:0] cmd_word;
    logic                start;
    gran_e               start_gran;

    assign raw_in = {spi_csn, spi_sck, spi_mosi};

    spi_erase_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn_in)
    );

    assign {csn_s, sck_s, mosi_s} = syn_in;

    // Edge history: previous synchronised clock and select levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_d <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            csn_d <= csn_s;
            sck_d <= sck_s;
        end
    end

    assign sck_rise = sck_s && !sck_d && !csn_s;
    assign sel_end  = csn_s && !csn_d;

    spi_erase_shifter #(
        .CMD_BITS (CMD_BITS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_active (!csn_s),
        .bit_strobe (sck_rise),
        .bit_in     (mosi_s),
        .bit_cnt    (bit_cnt),
        .cmd_word   (cmd_word)
    );

    spi_erase_ctrl #(
        .MEM_AW (MEM_AW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_end    (sel_end),
        .bit_cnt    (bit_cnt),
        .cmd_word   (cmd_word),
        .busy       (busy),
        .wren_set   (wren_set),
        .prot_map   (prot_map),
        .start      (start),
        .start_gran (start_gran),
        .erase_req  (erase_req),
        .erase_base (erase_base),
        .erase_size (erase_size),
        .wel        (wel)
    );

    spi_erase_timer #(
        .SECTOR_CYC (SECTOR_CYC),
        .BLOCK_CYC  (BLOCK_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .gran  (start_gran),
        .busy  (busy)
    );

endmodule

// File: rtl/spi_erase_front_chk.sv
// Module: assertion checker for spi_erase_front, attached by bind.
// Watches only the top-level ports. It measures busy windows with its
// own counter so that no long delay is unrolled.
module spi_erase_front_chk #(
    parameter int MEM_AW     = 18,
    parameter int SECTOR_CYC = 1000,
    parameter int BLOCK_CYC  = 4000,
    localparam int NUM_RGN   = 1 << (MEM_AW - 16)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_RGN-1:0] prot_map,
    input logic               erase_req,
    input logic [MEM_AW-1:0]  erase_base,
    input logic [1:0]         erase_size,
    input logic               busy,
    input logic               wel
);

    logic [31:0] run_len;
    logic [1:0]  run_size;

    // Busy window counter: restarts at each request, counts busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len  <= '0;
            run_size <= 2'b00;
        end else if (erase_req) begin
            run_len  <= 32'd1;
            run_size <= erase_size;
        end else if (busy) begin
            run_len  <= run_len + 1'b1;
        end
    end

    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    assert_wel_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !wel);

    assert_busy_with_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> erase_req);

    assert_busy_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == ((run_size == 2'b00) ? SECTOR_CYC : BLOCK_CYC));

    assert_no_req_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !$past(busy));

    assert_unprotected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !prot_map[erase_base[MEM_AW-1:16]]);

    assert_sector_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_size == 2'b00) |-> erase_base[11:0] == '0);

    assert_blk32_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_size == 2'b01) |-> erase_base[14:0] == '0);

    assert_blk64_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_size == 2'b10) |-> erase_base[15:0] == '0);

endmodule

bind spi_erase_front spi_erase_front_chk #(
    .MEM_AW     (MEM_AW),
    .SECTOR_CYC (SECTOR_CYC),
    .BLOCK_CYC  (BLOCK_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prot_map   (prot_map),
    .erase_req  (erase_req),
    .erase_base (erase_base),
    .erase_size (erase_size),
    .busy       (busy),
    .wel        (wel)
);

// File: tb/tb_spi_erase_front.sv
// Bench for spi_erase_front: a table of commands, then directed tests
// for reset and for a command that ends as the busy timer runs out.
module tb_spi_erase_front;

    localparam int MEM_AW = 18;
    localparam int SEC_N  = 300;
    localparam int BLK_N  = 500;
    localparam int HP     = 3;

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] addr;
        logic [5:0]  nbits;
        logic        mode3;
        logic        set_wel;
        logic [3:0]  prot;
        logic        exp_req;
        logic [17:0] exp_base;
        logic [1:0]  exp_size;
        logic        exp_wel;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h20, 24'h012345, 6'd32, 1'b0, 1'b1, 4'h0, 1'b1, 18'h12000, 2'b00, 1'b0}, // R2
        '{8'h52, 24'h01FFFF, 6'd32, 1'b1, 1'b1, 4'h0, 1'b1, 18'h18000, 2'b01, 1'b0}, // R3 R5 mode 3
        '{8'hD8, 24'h02ABCD, 6'd32, 1'b0, 1'b1, 4'h0, 1'b1, 18'h20000, 2'b10, 1'b0}, // R4
        '{8'h20, 24'h000FFF, 6'd32, 1'b1, 1'b0, 4'h0, 1'b0, 18'h00000, 2'b00, 1'b0}, // R7
        '{8'hD8, 24'h03FFFF, 6'd32, 1'b0, 1'b1, 4'h8, 1'b0, 18'h00000, 2'b00, 1'b0}, // R8
        '{8'h52, 24'h008000, 6'd32, 1'b0, 1'b1, 4'h8, 1'b1, 18'h08000, 2'b01, 1'b0}, // R8
        '{8'h20, 24'h004000, 6'd31, 1'b0, 1'b1, 4'h0, 1'b0, 18'h00000, 2'b00, 1'b1}, // R6
        '{8'h20, 24'h004000, 6'd33, 1'b0, 1'b1, 4'h0, 1'b0, 18'h00000, 2'b00, 1'b1}, // R6
        '{8'h03, 24'h001000, 6'd32, 1'b0, 1'b1, 4'h0, 1'b0, 18'h00000, 2'b00, 1'b1}, // R12
        '{8'h20, 24'hFF3000, 6'd32, 1'b1, 1'b1, 4'h0, 1'b1, 18'h33000, 2'b00, 1'b0}, // R5 high bits
        '{8'h52, 24'h03FFFF, 6'd32, 1'b0, 1'b1, 4'h7, 1'b1, 18'h38000, 2'b01, 1'b0}, // R8
        '{8'h20, 24'h010000, 6'd32, 1'b0, 1'b1, 4'h2, 1'b0, 18'h00000, 2'b00, 1'b0}  // R8
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spi_csn = 1'b1;
    logic              spi_sck = 1'b0;
    logic              spi_mosi = 1'b0;
    logic              wren_set = 1'b0;
    logic [3:0]        prot_map = 4'h0;
    logic              erase_req;
    logic [MEM_AW-1:0] erase_base;
    logic [1:0]        erase_size;
    logic              busy;
    logic              wel;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int req_n    = 0;
    int req_cyc  = 0;
    int busy_hi  = 0;
    logic [MEM_AW-1:0] req_base;
    logic [1:0]        req_size;

    spi_erase_front #(
        .MEM_AW     (MEM_AW),
        .SECTOR_CYC (SEC_N),
        .BLOCK_CYC  (BLK_N)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_csn    (spi_csn),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi),
        .wren_set   (wren_set),
        .prot_map   (prot_map),
        .erase_req  (erase_req),
        .erase_base (erase_base),
        .erase_size (erase_size),
        .busy       (busy),
        .wel        (wel)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: records requests and busy cycles away from the active edge.
    always @(negedge clk) begin
        if (rst_n && erase_req) begin
            req_n    = req_n + 1;
            req_cyc  = cyc;
            req_base = erase_base;
            req_size = erase_size;
        end
        if (rst_n && busy) busy_hi = busy_hi + 1;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_wren();
        @(negedge clk) wren_set = 1'b1;
        @(negedge clk) wren_set = 1'b0;
    endtask

    // Sends nbits of a command word with select held low; select stays low at the end.
    task automatic send_bits(input logic [31:0] w, input int nbits, input logic m3);
        @(negedge clk) spi_sck = m3;
        repeat (2) @(negedge clk);
        spi_csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = (i < 32) ? w[31-i] : 1'b0;
            repeat (HP) @(negedge clk);
            spi_sck = 1'b1;
            repeat (HP) @(negedge clk);
        end
        if (!m3) spi_sck = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int n0;
        int k;
        int m;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(wel == 1'b0, "R1 wel after reset", wel, 0);
        check(erase_req == 1'b0, "R1 erase_req after reset", erase_req, 0);

        // Table walk: one command per entry.
        for (int v = 0; v < NV; v++) begin
            prot_map = VECS[v].prot;
            if (VECS[v].set_wel) pulse_wren();
            n0      = req_n;
            busy_hi = 0;
            send_bits({VECS[v].op, VECS[v].addr}, int'(VECS[v].nbits), VECS[v].mode3);
            spi_csn = 1'b1;
            repeat (8) @(negedge clk);
            check(req_n == n0 + int'(VECS[v].exp_req), $sformatf("R2-R12 vec%0d request count", v),
                  req_n - n0, VECS[v].exp_req);
            check(wel == VECS[v].exp_wel, $sformatf("R7 vec%0d wel", v), wel, VECS[v].exp_wel);
            if (VECS[v].exp_req) begin
                check(req_base == VECS[v].exp_base, $sformatf("R5 vec%0d base", v), req_base, VECS[v].exp_base);
                check(req_size == VECS[v].exp_size, $sformatf("R2 R3 R4 vec%0d size", v), req_size, VECS[v].exp_size);
                wait_idle();
                check(busy_hi == ((VECS[v].exp_size == 2'b00) ? SEC_N : BLK_N),
                      $sformatf("R10 vec%0d busy cycles", v), busy_hi,
                      (VECS[v].exp_size == 2'b00) ? SEC_N : BLK_N);
            end
        end

        // Collision: the command is decided in the last busy cycle (R11).
        prot_map = 4'h0;
        pulse_wren();
        n0 = req_n;
        send_bits(32'h20000000, 32, 1'b0);
        spi_csn = 1'b1;
        while (req_n == n0) @(negedge clk);
        k = req_cyc;
        pulse_wren();
        send_bits(32'h20001000, 32, 1'b0);
        m = k + SEC_N - 3;
        while (cyc != m) @(negedge clk);
        spi_csn = 1'b1;
        repeat (8) @(negedge clk);
        check(req_n == n0 + 1, "R11 command ignored in last busy cycle", req_n - n0, 1);
        check(wel == 1'b1, "R11 wel kept by ignored command", wel, 1);
        wait_idle();

        // The latch kept by the ignored command allows the next erase (R11).
        n0 = req_n;
        send_bits(32'h20002000, 32, 1'b1);
        spi_csn = 1'b1;
        repeat (8) @(negedge clk);
        check(req_n == n0 + 1, "R11 erase after ignored one accepted", req_n - n0, 1);
        check(req_base == 18'h02000, "R11 base of follow-up erase", req_base, 18'h02000);
        k = req_cyc;

        // Decision in the first idle cycle is accepted, third edge after select rises (R9 R11).
        pulse_wren();
        n0 = req_n;
        send_bits(32'h20003000, 32, 1'b0);
        m = k + SEC_N - 2;
        while (cyc != m) @(negedge clk);
        spi_csn = 1'b1;
        repeat (8) @(negedge clk);
        check(req_n == n0 + 1, "R11 command in first idle cycle accepted", req_n - n0, 1);
        check(req_cyc == m + 3, "R9 request on third edge after select rise", req_cyc, m + 3);
        check(req_base == 18'h03000, "R9 base of boundary erase", req_base, 18'h03000);
        wait_idle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule